// File: doc/BRIEF.md
# Root Port PME Interrupt and System-Error Control

This block holds the interrupt and system-error policy of a PCI Express root port. Software reaches it through a small register interface with two words. The control word carries a PME interrupt enable and three per-severity system-error enables. The status word carries a PME pending flag. The flag is set when the message layer reports a received PME message, and software clears it by writing a one to it.

The level interrupt output is high whenever the pending flag and the interrupt enable are both set. Setting the enable while a PME is already pending therefore raises the interrupt. Dropping the enable, or clearing the flag, lowers it.

Error events arrive as one-cycle pulses from two places: the port's own error detection, and error messages received from devices further down the hierarchy. Each event is tagged correctable, non-fatal or fatal. An event whose severity is enabled produces a one-cycle system-error pulse. This happens whatever the generic command-register system-error enable says.

Top module: `rp_event_ctl`

## Requirements
- R1: After reset both register words read 0000h, and `pmeIrq` and `serrPulse` are low.
- R2: Address 0 is the control word. A write with `regBe[0]` set loads bits 3:0 from `regWdata[3:0]`. Reads of address 0 return those bits in 3:0.
- R3: Bits 15:4 of either word always read as zero, and writes to them are ignored. A write with `regBe[0]` clear (upper byte only) changes neither word.
- R4: Address 1 is the status word, with the PME pending flag in bit 0. A one-cycle `pmeRcvd` pulse sets the flag, and the flag reads back from the next cycle on.
- R5: Writing address 1 with `regBe[0]` set and `regWdata[0]`=1 clears the flag. Writing a 0 there leaves it unchanged. If a `pmeRcvd` pulse arrives in the same cycle as a clearing write, the flag ends up set.
- R6: `pmeIrq` is high exactly when the pending flag and control bit 3 are both set. Setting bit 3 while the flag is already set raises `pmeIrq` in the cycle after the write.
- R7: Clearing control bit 3 while `pmeIrq` is high lowers it in the cycle after the write. Clearing the flag does the same.
- R8: Control bit 2 enables fatal events, bit 1 non-fatal events and bit 0 correctable events. Local and message sources count alike. An enabled event raises `serrPulse` for one cycle, in the cycle after the event.
- R9: An event whose severity enable bit is clear produces no `serrPulse`.
- R10: `cmdSerrEn` has no effect. Enabled events pulse `serrPulse` with it low, and disabled events stay silent with it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write request |
| regAddr | input | 1 | Word select: 0 control, 1 status |
| regBe | input | 2 | Per-byte write enables |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the addressed word (combinational) |
| pmeRcvd | input | 1 | One-cycle pulse: PME message received |
| cmdSerrEn | input | 1 | Generic command-register system-error enable (overridden) |
| localCor | input | 1 | Port-detected correctable error pulse |
| localNonFatal | input | 1 | Port-detected non-fatal error pulse |
| localFatal | input | 1 | Port-detected fatal error pulse |
| msgCor | input | 1 | Correctable error message received pulse |
| msgNonFatal | input | 1 | Non-fatal error message received pulse |
| msgFatal | input | 1 | Fatal error message received pulse |
| pmeIrq | output | 1 | Level PME interrupt |
| serrPulse | output | 1 | One-cycle system-error pulse |

## Verification
Read data depends only on the address and the stored state, so it is due in the same cycle the address is presented. Writes, PME arrivals and flag clears take effect at the next rising edge, so their effect on read data and on `pmeIrq` is due one cycle later. `serrPulse` comes from a register and is due exactly one cycle after the event. The check uses the control word as it stood before any write in that same cycle. The bench drives every input on the falling edge, updates its model at the rising edge, and compares on the following falling edge, so each comparison lands in the cycle its result is due.

// File: rtl/rp_event_pkg.sv
package rp_event_pkg;
  localparam int REG_W = 16;
  localparam int CTL_W = 4;
  localparam int SEV_N = 3;

  // strobes handed from the register decoder to the datapath
  typedef struct packed {
    logic ctlWr;
    logic stsClr;
    logic selSts;
  } rpStrobe_t;
endpackage

// File: rtl/rp_event_ctrl.sv
module rp_event_ctrl
  import rp_event_pkg::*;
#(
  parameter int BE_W = REG_W / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic            regAddr,
  input  logic [BE_W-1:0] regBe,
  input  logic            clrBit,
  output rpStrobe_t       strobe
);
  always_comb begin
    strobe.ctlWr  = regWe && !regAddr && regBe[0];
    strobe.stsClr = regWe &&  regAddr && regBe[0] && clrBit;
    strobe.selSts = regAddr;
  end

  // R3
  upper_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regBe[0] && (regBe[BE_W-1:1] != '0)) |-> (!strobe.ctlWr && !strobe.stsClr));
endmodule

// File: rtl/rp_event_dp.sv
module rp_event_dp
  import rp_event_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int CW = CTL_W,
  parameter int SN = SEV_N
) (
  input  logic          clk,
  input  logic          rstN,
  input  rpStrobe_t     strobe,
  input  logic [CW-1:0] ctlIn,
  input  logic          pmeRcvd,
  input  logic          cmdSerrEn,
  input  logic [SN-1:0] localEvt,
  input  logic [SN-1:0] msgEvt,
  output logic [RW-1:0] regRdata,
  output logic          pmeIrq,
  output logic          serrPulse
);
  localparam int PME_BIT = CW - 1;

  logic [CW-1:0] ctlReg;
  logic          pmeSts;
  logic [SN-1:0] sevHit;

  always_ff @(posedge clk) begin
    if (!rstN) ctlReg <= '0;
    else if (strobe.ctlWr) ctlReg <= ctlIn;
  end

  // an arriving PME wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) pmeSts <= 1'b0;
    else if (pmeRcvd) pmeSts <= 1'b1;
    else if (strobe.stsClr) pmeSts <= 1'b0;
  end

  for (genvar i = 0; i < SN; i++) begin : g_sev
    assign sevHit[i] = (localEvt[i] | msgEvt[i]) & ctlReg[i];

    // R8 R10
    sev_serr_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((localEvt[i] || msgEvt[i]) && ctlReg[i] && !cmdSerrEn) |=> serrPulse);
  end

  always_ff @(posedge clk) begin
    if (!rstN) serrPulse <= 1'b0;
    else serrPulse <= |sevHit;
  end

  assign pmeIrq   = pmeSts & ctlReg[PME_BIT];
  assign regRdata = strobe.selSts ? RW'(pmeSts) : RW'(ctlReg);

  // R9 R10
  no_serr_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((localEvt | msgEvt) & ctlReg[SN-1:0]) == '0) |=> !serrPulse);
  // R4
  sts_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmeRcvd |=> pmeSts);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctlReg[PME_BIT]) && pmeSts) |-> pmeIrq);
  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlReg[PME_BIT]) |-> !pmeIrq);
endmodule

// File: rtl/rp_event_ctl.sv
module rp_event_ctl
  import rp_event_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int CW = CTL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic          regAddr,
  input  logic [1:0]    regBe,
  input  logic [RW-1:0] regWdata,
  output logic [RW-1:0] regRdata,
  input  logic          pmeRcvd,
  input  logic          cmdSerrEn,
  input  logic          localCor,
  input  logic          localNonFatal,
  input  logic          localFatal,
  input  logic          msgCor,
  input  logic          msgNonFatal,
  input  logic          msgFatal,
  output logic          pmeIrq,
  output logic          serrPulse
);
  rpStrobe_t strobe;

  rp_event_ctrl #(.BE_W(2)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regWe  (regWe),
    .regAddr(regAddr),
    .regBe  (regBe),
    .clrBit (regWdata[0]),
    .strobe (strobe)
  );

  rp_event_dp #(.RW(RW), .CW(CW), .SN(SEV_N)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ctlIn    (regWdata[CW-1:0]),
    .pmeRcvd  (pmeRcvd),
    .cmdSerrEn(cmdSerrEn),
    .localEvt ({localFatal, localNonFatal, localCor}),
    .msgEvt   ({msgFatal, msgNonFatal, msgCor}),
    .regRdata (regRdata),
    .pmeIrq   (pmeIrq),
    .serrPulse(serrPulse)
  );

  // R3
  rsvd_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regBe[0] && (regWdata[RW-1:CW] != '0)) |=> (regRdata[RW-1:CW] == '0));
endmodule

// File: tb/rp_event_ctl_bench.sv
module rp_event_ctl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regAddr = 1'b0;
  logic [1:0] regBe = '0;
  logic [15:0] regWdata = '0, regRdata;
  logic pmeRcvd = 1'b0, cmdSerrEn = 1'b0;
  logic [5:0] ev = '0;  // [2:0] local cor/nonfatal/fatal, [5:3] message
  logic pmeIrq, serrPulse;

  int nChk = 0, nFail = 0;
  logic [3:0] mCtl = '0;
  logic mSts = 1'b0, mSerr = 1'b0;

  always #5 clk = ~clk;

  rp_event_ctl u_rp_event_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regBe(regBe),
    .regWdata(regWdata), .regRdata(regRdata), .pmeRcvd(pmeRcvd), .cmdSerrEn(cmdSerrEn),
    .localCor(ev[0]), .localNonFatal(ev[1]), .localFatal(ev[2]),
    .msgCor(ev[3]), .msgNonFatal(ev[4]), .msgFatal(ev[5]),
    .pmeIrq(pmeIrq), .serrPulse(serrPulse)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRd(input logic a);
    return a ? {15'b0, mSts} : {12'b0, mCtl};
  endfunction

  // called on a falling edge; returns on the next falling edge
  task automatic cyc(input logic we, input logic a, input logic [1:0] be,
                     input logic [15:0] wd, input logic pme, input logic cmd,
                     input logic [5:0] e);
    logic [3:0] nCtl;
    logic nSts, nSerr;
    regWe = we; regAddr = a; regBe = be; regWdata = wd;
    pmeRcvd = pme; cmdSerrEn = cmd; ev = e;
    #1;
    chk(a ? "R4 read" : "R2 read", regRdata, expRd(a));
    nCtl = (we && !a && be[0]) ? wd[3:0] : mCtl;
    nSts = pme ? 1'b1 : ((we && a && be[0] && wd[0]) ? 1'b0 : mSts);
    nSerr = |((e[2:0] | e[5:3]) & mCtl[2:0]);
    @(posedge clk);
    mCtl = nCtl; mSts = nSts; mSerr = nSerr;
    @(negedge clk);
    chk("R6 irq", {15'b0, pmeIrq}, {15'b0, mSts & mCtl[3]});
    chk("R8 serr", {15'b0, serrPulse}, {15'b0, mSerr});
  endtask

  task automatic idle(input logic a);
    cyc(1'b0, a, 2'b00, 16'h0, 1'b0, 1'b0, 6'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regAddr = 1'b0; #1;
    chk("R1 ctl", regRdata, 16'h0);
    regAddr = 1'b1; #1;
    chk("R1 sts", regRdata, 16'h0);
    chk("R1 irq", {15'b0, pmeIrq}, 16'h0);
    chk("R1 serr", {15'b0, serrPulse}, 16'h0);
    @(negedge clk);

    // R2 R3: full write, reserved bits stay zero
    cyc(1'b1, 1'b0, 2'b11, 16'hFFF7, 1'b0, 1'b0, 6'h0);
    chk("R3 rsvd", regRdata, 16'h0007);
    // R3: upper-byte-only write changes nothing
    cyc(1'b1, 1'b0, 2'b10, 16'h0000, 1'b0, 1'b0, 6'h0);
    chk("R3 upper only", regRdata, 16'h0007);
    cyc(1'b1, 1'b1, 2'b10, 16'hFFFF, 1'b1, 1'b0, 6'h0);
    cyc(1'b1, 1'b1, 2'b10, 16'hFFFF, 1'b0, 1'b0, 6'h0);
    chk("R3 upper only sts", regRdata, 16'h0001);
    cyc(1'b1, 1'b1, 2'b01, 16'h0001, 1'b0, 1'b0, 6'h0);

    // R8 each severity, both sources, single-cycle pulse
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 6'(1 << i));
      chk("R8 pulse", {15'b0, serrPulse}, 16'h1);
      idle(1'b0);
      chk("R8 one cycle", {15'b0, serrPulse}, 16'h0);
    end
    // R9 R10: all severities off, command enable high
    cyc(1'b1, 1'b0, 2'b01, 16'h0000, 1'b0, 1'b1, 6'h0);
    cyc(1'b0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b1, 6'h3F);
    chk("R9 R10 disabled", {15'b0, serrPulse}, 16'h0);
    // R9: only correctable enabled, fatal event ignored
    cyc(1'b1, 1'b0, 2'b01, 16'h0001, 1'b0, 1'b1, 6'h0);
    cyc(1'b0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b1, 6'h24);
    chk("R9 fatal off", {15'b0, serrPulse}, 16'h0);
    // R10: enabled with command enable low
    cyc(1'b0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 6'h08);
    chk("R10 override", {15'b0, serrPulse}, 16'h1);

    // R6: PME with enable off, then enable rises
    cyc(1'b1, 1'b0, 2'b01, 16'h0000, 1'b1, 1'b0, 6'h0);
    chk("R6 no irq when off", {15'b0, pmeIrq}, 16'h0);
    cyc(1'b1, 1'b0, 2'b01, 16'h0008, 1'b0, 1'b0, 6'h0);
    chk("R6 enable rise", {15'b0, pmeIrq}, 16'h1);
    // R7: enable falls
    cyc(1'b1, 1'b0, 2'b01, 16'h0000, 1'b0, 1'b0, 6'h0);
    chk("R7 enable fall", {15'b0, pmeIrq}, 16'h0);
    cyc(1'b1, 1'b0, 2'b01, 16'h0008, 1'b0, 1'b0, 6'h0);
    // R5: writing zero keeps the flag
    cyc(1'b1, 1'b1, 2'b01, 16'h0000, 1'b0, 1'b0, 6'h0);
    chk("R5 write zero", regRdata, 16'h0001);
    // R5 R7: clear drops flag and irq
    cyc(1'b1, 1'b1, 2'b01, 16'h0001, 1'b0, 1'b0, 6'h0);
    chk("R5 clear", regRdata, 16'h0000);
    chk("R7 clear drops irq", {15'b0, pmeIrq}, 16'h0);
    // R5: arrival during clear wins
    cyc(1'b1, 1'b1, 2'b01, 16'h0001, 1'b1, 1'b0, 6'h0);
    chk("R5 set wins", regRdata, 16'h0001);
    chk("R6 irq after set", {15'b0, pmeIrq}, 16'h1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] e;
      e = 6'($urandom) & 6'($urandom) & 6'($urandom);
      cyc(($urandom % 4) == 0, 1'($urandom), 2'($urandom), 16'($urandom),
          ($urandom % 8) == 0, 1'($urandom), e);
    end

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule